// File: doc/BRIEF.md
# Clock Generator Power Sequencer

This block orders the steps that bring a programmable clock generator down into its low-power state and back up. It also runs the first bring-up after a reset. It drives the enables for the internal oscillator and the external clock input buffer, a gate for the master clock, drive enables for the divided and undivided clock outputs, a reset for the divide counters, and three one-shot requests toward the divisor logic: force both divisors to maximum, restore the programmed divisors, and load the divisors from non-volatile storage. The load request is held until storage acknowledges it.

A shared control pin either requests power-down (when the mode input is 1) or selects the clock source (when the mode input is 0). In the second case this block treats the device as permanently powered. The pin passes through a two-flop synchronizer. Every bring-up forces maximum divisors and then waits 256 master-clock cycles so the oscillator can settle before any output is driven. On the way down, the divided output is put into high impedance only after it has been seen low, so it never stops in mid-pulse.

Top module: `clkgen_pwr_seq`

## Requirements
- R1: While `rst_n` is low, every enable and request output is 0 and `busy` is 1. After release, the block holds that state for two more cycles (reset release synchronizer) and then starts the bring-up with the storage-load variant.
- R2: The control pin passes through two flops before the sequencer sees it. When `pd_mode` is 0 the pin has no effect, and an idle powered-down block powers up.
- R3: Power-down starts by dropping `div_run` and pulsing `cnt_rst` for exactly one cycle. `div_oe` stays 1 during this cycle.
- R4: `div_oe` falls only in the cycle after `div_lvl` was sampled 0. While `div_lvl` stays 1, the divided output remains driven.
- R5: One cycle after `div_oe` falls, `mclk_gate` and `und_oe` fall. One cycle after that, `osc_en` and `buf_en` fall, and the next cycle the block is idle.
- R6: Bring-up starts by raising `osc_en`, `buf_en` and `mclk_gate` together with a one-cycle `force_max` pulse. At most one of the four requests is high in any cycle.
- R7: Exactly 256 cycles separate the `force_max` cycle from the next request cycle (the `force_max` sample is 257 cycles before the request sample).
- R8: After a wake from power-down, `restore_div` pulses for one cycle. The undivided output is enabled in the next cycle, and `div_oe` and `div_run` rise one cycle after that.
- R9: After reset, `nvm_load_req` is raised in place of `restore_div` and held until `nvm_ack` is sampled 1. The sequence then continues as in R8.
- R10: `und_oe` is 1 only while the enable bit `en0_n` is 0. With `en0_n` at 1 the undivided output is never driven.
- R11: `busy` is 1 in every sequence step and 0 only in the fully-up and fully-down idle states. No request is issued while `busy` is 0.
- R12: A pin change during a sequence does not interrupt it. When the sequence completes, the pin level at that moment decides, so the completed idle state lasts one cycle before the opposite sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin | input | 1 | Shared control pin, asynchronous; low requests power-down |
| pd_mode | input | 1 | 1: pin acts as power-down; 0: pin is a source select and is ignored here |
| en0_n | input | 1 | Undivided output enable bit, active low |
| div_lvl | input | 1 | Current level of the divided output |
| nvm_ack | input | 1 | Storage acknowledges the divisor load |
| osc_en | output | 1 | Internal oscillator enable |
| buf_en | output | 1 | External clock input buffer enable |
| mclk_gate | output | 1 | Master clock gate enable |
| div_oe | output | 1 | Divided output drive enable (0 = high impedance) |
| und_oe | output | 1 | Undivided output drive enable (0 = high impedance) |
| div_run | output | 1 | Divided output toggling enable |
| cnt_rst | output | 1 | Divide counter reset pulse |
| force_max | output | 1 | Force both divisors to maximum, one-cycle pulse |
| restore_div | output | 1 | Restore programmed divisors, one-cycle pulse |
| nvm_load_req | output | 1 | Request divisor load from storage, held until acknowledged |
| busy | output | 1 | High during any sequence |

## Verification
All outputs are decoded from the state register, so they respond on the first edge that samples a step's condition. Examples are `div_lvl` low, `nvm_ack` high and the settling counter's last count. A pin change reaches the state two edges later, after the synchronizer. The bench models the reset release flops, the pin synchronizer and the step order, advancing them on each rising edge. It compares every output on each falling edge, so the model and the design have both taken the same edge before a compare. Timed checks count falling-edge samples, for example 257 samples from the `force_max` sample to the `restore_div` sample, and exactly one idle sample before a queued power-down.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;

  typedef enum logic [3:0] {
    SQ_RESET,
    SQ_UP_OSC,
    SQ_UP_WAIT,
    SQ_UP_LOAD,
    SQ_UP_RESTORE,
    SQ_UP_UND,
    SQ_UP_DIV,
    SQ_ON,
    SQ_DN_DIS,
    SQ_DN_WAITLOW,
    SQ_DN_TRI,
    SQ_DN_GATE,
    SQ_DN_OSC,
    SQ_OFF
  } seq_state_e;

  typedef struct packed {
    logic osc_en;
    logic buf_en;
    logic mclk_gate;
    logic div_oe;
    logic div_run;
    logic und_act;
    logic cnt_rst;
    logic force_max;
    logic restore;
    logic load_req;
    logic busy;
  } seq_ctl_t;

endpackage

// File: rtl/clkpwr_sync.sv
module clkpwr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/clkpwr_stab_cnt.sv
module clkpwr_stab_cnt #(
  parameter int unsigned STAB_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int unsigned W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(STAB_CYCLES - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (done) cnt_d = '0;
    else           cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run)) else $error("settle count ended without a running window"); // R7

endmodule

// File: rtl/clkpwr_fsm.sv
module clkpwr_fsm
  import clkpwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     want_on,
  input  logic     div_lvl,
  input  logic     nvm_ack,
  input  logic     stab_done,
  output logic     stab_run,
  output seq_ctl_t ctl
);

  seq_state_e state_q, state_d;
  logic       por_q, por_d;

  always_comb begin
    state_d = state_q;
    por_d   = por_q;
    unique case (state_q)
      SQ_RESET:      state_d = SQ_UP_OSC;
      SQ_UP_OSC:     state_d = SQ_UP_WAIT;
      SQ_UP_WAIT:    if (stab_done) state_d = por_q ? SQ_UP_LOAD : SQ_UP_RESTORE;
      SQ_UP_LOAD:    if (nvm_ack) begin
                       state_d = SQ_UP_UND;
                       por_d   = 1'b0;
                     end
      SQ_UP_RESTORE: state_d = SQ_UP_UND;
      SQ_UP_UND:     state_d = SQ_UP_DIV;
      SQ_UP_DIV:     state_d = SQ_ON;
      SQ_ON:         if (!want_on) state_d = SQ_DN_DIS;
      SQ_DN_DIS:     state_d = SQ_DN_WAITLOW;
      SQ_DN_WAITLOW: if (!div_lvl) state_d = SQ_DN_TRI;
      SQ_DN_TRI:     state_d = SQ_DN_GATE;
      SQ_DN_GATE:    state_d = SQ_DN_OSC;
      SQ_DN_OSC:     state_d = SQ_OFF;
      SQ_OFF:        if (want_on) state_d = SQ_UP_OSC;
      default:       state_d = SQ_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_RESET;
      por_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      por_q   <= por_d;
    end
  end

  assign stab_run = (state_q == SQ_UP_WAIT);

  always_comb begin
    ctl      = '0;
    ctl.busy = 1'b1;
    unique case (state_q)
      SQ_RESET: ;
      SQ_UP_OSC: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.force_max = 1'b1;
      end
      SQ_UP_WAIT: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
      end
      SQ_UP_LOAD: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.load_req = 1'b1;
      end
      SQ_UP_RESTORE: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.restore = 1'b1;
      end
      SQ_UP_UND: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.und_act = 1'b1;
      end
      SQ_UP_DIV, SQ_ON: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.und_act = 1'b1; ctl.div_oe = 1'b1; ctl.div_run = 1'b1;
        ctl.busy = (state_q != SQ_ON);
      end
      SQ_DN_DIS, SQ_DN_WAITLOW: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.und_act = 1'b1; ctl.div_oe = 1'b1;
        ctl.cnt_rst = (state_q == SQ_DN_DIS);
      end
      SQ_DN_TRI: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1; ctl.mclk_gate = 1'b1;
        ctl.und_act = 1'b1;
      end
      SQ_DN_GATE: begin
        ctl.osc_en = 1'b1; ctl.buf_en = 1'b1;
      end
      SQ_DN_OSC: ;
      SQ_OFF:    ctl.busy = 1'b0;
      default: ;
    endcase
  end

  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.cnt_rst, ctl.force_max, ctl.restore, ctl.load_req})) else $error("two requests at once"); // R6
  AST_TRI_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.div_oe) |-> !$past(div_lvl)) else $error("divided output released while high"); // R4
  AST_RESTORE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.restore) |-> $past(stab_done)) else $error("restore before settle time"); // R7
  AST_LOAD_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.load_req) |-> $past(stab_done)) else $error("load before settle time"); // R9
  AST_GATE_AFTER_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl.mclk_gate) |-> !ctl.div_oe) else $error("clock gated with divided output driven"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.busy |-> !(ctl.cnt_rst || ctl.force_max || ctl.restore || ctl.load_req)) else $error("request while idle"); // R11
  AST_RUN_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.div_run |-> (ctl.osc_en && ctl.mclk_gate)) else $error("divider running without clock"); // R8

endmodule

// File: rtl/clkgen_pwr_seq.sv
module clkgen_pwr_seq
  import clkpwr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAB_CYCLES = 256
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic pd_pin,
  input  logic pd_mode,
  input  logic en0_n,
  input  logic div_lvl,
  input  logic nvm_ack,
  output logic osc_en,
  output logic buf_en,
  output logic mclk_gate,
  output logic div_oe,
  output logic und_oe,
  output logic div_run,
  output logic cnt_rst,
  output logic force_max,
  output logic restore_div,
  output logic nvm_load_req,
  output logic busy
);

  logic     rst_q;
  logic     pin_s;
  logic     want_on;
  logic     stab_run;
  logic     stab_done;
  seq_ctl_t ctl;

  clkpwr_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(mclk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  clkpwr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(mclk), .rst_n(rst_q), .d(pd_pin), .q(pin_s)
  );

  assign want_on = !pd_mode || pin_s;

  clkpwr_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_stab (
    .clk(mclk), .rst_n(rst_q), .run(stab_run), .done(stab_done)
  );

  clkpwr_fsm u_fsm (
    .clk(mclk), .rst_n(rst_q), .want_on(want_on), .div_lvl(div_lvl),
    .nvm_ack(nvm_ack), .stab_done(stab_done), .stab_run(stab_run), .ctl(ctl)
  );

  assign osc_en       = ctl.osc_en;
  assign buf_en       = ctl.buf_en;
  assign mclk_gate    = ctl.mclk_gate;
  assign div_oe       = ctl.div_oe;
  assign div_run      = ctl.div_run;
  assign und_oe       = ctl.und_act && !en0_n;
  assign cnt_rst      = ctl.cnt_rst;
  assign force_max    = ctl.force_max;
  assign restore_div  = ctl.restore;
  assign nvm_load_req = ctl.load_req;
  assign busy         = ctl.busy;

  AST_UND_NEEDS_CLK: assert property (@(posedge mclk) disable iff (!rst_q)
    und_oe |-> (mclk_gate && osc_en)) else $error("undivided output driven without clock"); // R5

endmodule

// File: tb/test_clkgen_pwr_seq.sv
module test_clkgen_pwr_seq;

  localparam int STAB = 256;
  localparam int P_RST = 0, P_OSC = 1, P_WAIT = 2, P_LOAD = 3, P_REST = 4, P_UND = 5,
                 P_DIV = 6, P_ON = 7, P_DIS = 8, P_WLOW = 9, P_TRI = 10, P_GATE = 11,
                 P_OSCOFF = 12, P_OFF = 13;

  logic clk = 1'b0;
  logic rst_n, pd_pin, pd_mode, en0_n, div_lvl, nvm_ack;
  logic osc_en, buf_en, mclk_gate, div_oe, und_oe, div_run;
  logic cnt_rst, force_max, restore_div, nvm_load_req, busy;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit started = 0;
  bit done_flag = 0;

  // behavioural reference state
  bit m_r1, m_r2, m_p1, m_p2, m_por;
  int m_ph, m_t;

  always #2.5 clk = ~clk;

  clkgen_pwr_seq i_clkgen_pwr_seq (
    .mclk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pd_mode(pd_mode), .en0_n(en0_n),
    .div_lvl(div_lvl), .nvm_ack(nvm_ack), .osc_en(osc_en), .buf_en(buf_en),
    .mclk_gate(mclk_gate), .div_oe(div_oe), .und_oe(und_oe), .div_run(div_run),
    .cnt_rst(cnt_rst), .force_max(force_max), .restore_div(restore_div),
    .nvm_load_req(nvm_load_req), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    started <= 1'b1;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_p1 = 1; m_p2 = 1; m_ph = P_RST; m_t = 0; m_por = 1;
    end else begin
      if (!m_r2) begin
        m_p1 = 1; m_p2 = 1; m_ph = P_RST; m_t = 0; m_por = 1;
      end else begin
        bit want;
        want = !pd_mode || m_p2;
        case (m_ph)
          P_RST:    m_ph = P_OSC;
          P_OSC:    begin m_ph = P_WAIT; m_t = 0; end
          P_WAIT:   if (m_t == STAB - 1) m_ph = m_por ? P_LOAD : P_REST; else m_t++;
          P_LOAD:   if (nvm_ack) begin m_ph = P_UND; m_por = 0; end
          P_REST:   m_ph = P_UND;
          P_UND:    m_ph = P_DIV;
          P_DIV:    m_ph = P_ON;
          P_ON:     if (!want) m_ph = P_DIS;
          P_DIS:    m_ph = P_WLOW;
          P_WLOW:   if (!div_lvl) m_ph = P_TRI;
          P_TRI:    m_ph = P_GATE;
          P_GATE:   m_ph = P_OSCOFF;
          P_OSCOFF: m_ph = P_OFF;
          P_OFF:    if (want) m_ph = P_OSC;
          default:  m_ph = P_RST;
        endcase
        m_p2 = m_p1; m_p1 = pd_pin;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  function automatic bit in_set(int ph, int lo, int hi);
    return (ph >= lo) && (ph <= hi);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string nm);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done_flag) begin
      chk(osc_en,       in_set(m_ph, P_OSC, P_GATE),                   "R6",  "osc_en");
      chk(buf_en,       in_set(m_ph, P_OSC, P_GATE),                   "R6",  "buf_en");
      chk(mclk_gate,    in_set(m_ph, P_OSC, P_TRI),                    "R5",  "mclk_gate");
      chk(div_oe,       in_set(m_ph, P_DIV, P_WLOW),                   "R4",  "div_oe");
      chk(div_run,      in_set(m_ph, P_DIV, P_ON),                     "R8",  "div_run");
      chk(und_oe,       in_set(m_ph, P_UND, P_TRI) && !en0_n,          "R10", "und_oe");
      chk(cnt_rst,      m_ph == P_DIS,                                 "R3",  "cnt_rst");
      chk(force_max,    m_ph == P_OSC,                                 "R6",  "force_max");
      chk(restore_div,  m_ph == P_REST,                                "R8",  "restore_div");
      chk(nvm_load_req, m_ph == P_LOAD,                                "R9",  "nvm_load_req");
      chk(busy,         !(m_ph == P_ON || m_ph == P_OFF),              "R11", "busy");
    end
  end

  task automatic finish_run();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    finish_run();
  end

  initial begin
    int t0, n;
    rst_n = 0; pd_pin = 1; pd_mode = 1; en0_n = 0; div_lvl = 1; nvm_ack = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(busy, 1'b1, "R1", "busy in reset");
    chk(osc_en | mclk_gate | div_oe | und_oe | nvm_load_req | force_max, 1'b0, "R1", "enables in reset");
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(force_max, 1'b0, "R1", "held by release sync");
    @(negedge clk);
    chk(force_max, 1'b1, "R1", "bring-up starts");
    // R9: storage load handshake
    while (!nvm_load_req) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(nvm_load_req, 1'b1, "R9", "load held without ack");
    nvm_ack = 1; @(negedge clk); nvm_ack = 0;
    while (busy) @(negedge clk);
    chk(div_run, 1'b1, "R9", "running after load");
    // R3/R4/R5: power-down waits for a low divided output
    pd_pin = 0;
    while (!cnt_rst) @(negedge clk);
    chk(div_oe, 1'b1, "R3", "div_oe held in first step");
    repeat (6) @(negedge clk);
    chk(div_oe, 1'b1, "R4", "div_oe while level high");
    div_lvl = 0;
    while (busy) @(negedge clk);
    chk(osc_en, 1'b0, "R5", "oscillator off at end");
    // R7/R12: wake with restore, pin drops during the wait
    pd_pin = 1;
    while (!force_max) @(negedge clk);
    t0 = cyc;
    pd_pin = 0;
    while (!restore_div) @(negedge clk);
    chk(cyc - t0 == STAB + 1, 1'b1, "R7", "settle window length");
    while (busy) @(negedge clk);
    n = 0;
    while (!busy) begin n++; @(negedge clk); end
    chk(n == 1, 1'b1, "R12", "one idle cycle before queued power-down");
    chk(cnt_rst, 1'b1, "R12", "queued power-down starts");
    while (busy) @(negedge clk);
    // R2: mode 0 ignores the pin and brings the block up
    pd_mode = 0;
    while (!force_max) @(negedge clk);
    while (busy) @(negedge clk);
    chk(und_oe, 1'b1, "R8", "undivided output on");
    pd_pin = 1; repeat (3) @(negedge clk); pd_pin = 0; repeat (5) @(negedge clk);
    chk(busy | !div_run, 1'b0, "R2", "pin ignored in select mode");
    en0_n = 1; @(negedge clk);
    chk(und_oe, 1'b0, "R10", "enable bit off");
    pd_mode = 1;
    while (busy == 0) @(negedge clk);
    while (busy) @(negedge clk);
    chk(mclk_gate, 1'b0, "R5", "gated after mode restored");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule